// File: doc/BRIEF.md
# Wide-Group Lane Sequencer

This block takes one instruction per clock for a thread group that is wider than the physical SIMD units behind it. It splits the group's active mask into unit-width slices and sends those slices to one of two identical units, one slice per clock. The lowest slice goes first. Two units take turns, so a new instruction can start on the second unit while the first unit is still working through the slices of the previous one. This keeps both units busy, and no dependency check between instructions is needed.

The instruction port uses a valid/ready handshake. Each accepted instruction is shown to the caller through `iss_unit`, which names the unit it went to. The slice outputs come from registers in each unit. Once the final slice of an instruction has gone into a unit, a fixed-latency pipe model raises a completion pulse for that unit, `PIPE_LAT` clocks later. `GROUP_W` must be a whole multiple of `UNIT_W`.

Top module: `grp_lane_seq`

## Requirements
- R1: Out of reset, `iss_ready` is 1, `iss_unit` is 0, and every `sl_valid` and `cmp_valid` bit is 0.
- R2: An instruction accepted in cycle c appears on its unit in cycles c+1 to c+N, where N = GROUP_W/UNIT_W. In cycle c+1+k the slice index is k, and the slice mask is bits [k*UNIT_W +: UNIT_W] of the accepted mask. The opcode is shown alongside every slice. Unit u uses field u of each packed slice output.
- R3: `iss_ready` is 0 only while both units are busy. An instruction offered while `iss_ready` is 0 is dropped and produces no slice.
- R4: A unit is busy from the cycle after acceptance until the cycle before its final slice. It can accept a new instruction in the same cycle it presents its final slice, so the next instruction follows with no gap.
- R5: When both units are free, the instruction goes to the unit that did not take the previous one. The first instruction after reset goes to unit 0. When only one unit is free, the instruction goes to that unit.
- R6: A slice whose sub-mask is all zero still uses its cycle and its index, but `sl_valid` stays 0 for that cycle.
- R7: The bit `cmp_valid[u]` pulses for exactly one cycle, PIPE_LAT cycles after unit u presented an instruction's final slice. The pulse comes with that instruction's opcode, and it appears even when the whole mask is zero.
- R8: Instructions offered every cycle are accepted at the rate the two units free up, alternating between them. With N=2 this is one instruction per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Instruction offered |
| iss_op | input | OP_W | Opcode tag |
| iss_mask | input | GROUP_W | Active-lane mask of the group |
| iss_ready | output | 1 | At least one unit can accept |
| iss_unit | output | 1 | Unit an instruction offered this cycle goes to |
| sl_valid | output | 2 | Per unit: slice present with a non-zero sub-mask |
| sl_idx | output | 2*SIDX_W | Per unit: slice index |
| sl_mask | output | 2*UNIT_W | Per unit: slice sub-mask |
| sl_op | output | 2*OP_W | Per unit: opcode of the slice |
| cmp_valid | output | 2 | Per unit: completion pulse |
| cmp_op | output | 2*OP_W | Per unit: opcode of the completed instruction |

## Verification
A slice counter that is wrong shows up on the slice index, or on a sub-mask taken from the wrong lanes, in the very next cycle. It also moves that unit's final slice, and with it the ready timing and the completion pulse, which arrives PIPE_LAT cycles off. A wrong busy or turn-taking state makes `iss_ready` or `iss_unit` wrong in the same cycle an instruction is offered. It then puts slices on the other unit's outputs from the following cycle onward. A failed zero-slice test appears as a `sl_valid` pulse in a cycle that should be empty.

// File: rtl/lseq_pkg.sv
package lseq_pkg;
  localparam int NUM_UNITS = 2;
  typedef logic unit_id_t;

  // steering: alternate when both are free, otherwise the free one
  function automatic unit_id_t pick_unit(input logic [1:0] free, input unit_id_t prev);
    if (free == 2'b11) return ~prev;
    else if (free[1]) return 1'b1;
    else return 1'b0;
  endfunction
endpackage

// File: rtl/lseq_slicer.sv
module lseq_slicer #(
  parameter int GROUP_W = 64,
  parameter int UNIT_W  = 16,
  parameter int OP_W    = 6,
  localparam int NSLICE = GROUP_W / UNIT_W,
  localparam int SIDX_W = (NSLICE > 1) ? $clog2(NSLICE) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [OP_W-1:0]    ld_op,
  input  logic [GROUP_W-1:0] ld_mask,
  output logic               busy,
  output logic               fin,
  output logic               sl_valid,
  output logic [SIDX_W-1:0]  sl_idx,
  output logic [UNIT_W-1:0]  sl_mask,
  output logic [OP_W-1:0]    sl_op
);
  logic               active;
  logic [SIDX_W-1:0]  idx;
  logic [OP_W-1:0]    op_q;
  logic [GROUP_W-1:0] mask_q;
  logic               last;
  logic [UNIT_W-1:0]  sub;

  function automatic logic [UNIT_W-1:0] slice_of(input logic [GROUP_W-1:0] m,
                                                 input logic [SIDX_W-1:0] k);
    return m[k*UNIT_W +: UNIT_W];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      op_q   <= '0;
      mask_q <= '0;
    end else if (load) begin
      active <= 1'b1;
      idx    <= '0;
      op_q   <= ld_op;
      mask_q <= ld_mask;
    end else if (active) begin
      if (last) begin
        active <= 1'b0;
        idx    <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  assign last     = active && (idx == SIDX_W'(NSLICE - 1));
  assign busy     = active && !last;
  assign fin      = last;
  assign sub      = slice_of(mask_q, idx);
  assign sl_mask  = active ? sub : '0;
  assign sl_valid = active && (|sub);
  assign sl_idx   = active ? idx : '0;
  assign sl_op    = active ? op_q : '0;
endmodule

// File: rtl/lseq_delay.sv
module lseq_delay #(
  parameter int LAT  = 3,
  parameter int OP_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_v,
  input  logic [OP_W-1:0] in_op,
  output logic            out_v,
  output logic [OP_W-1:0] out_op
);
  logic            vld [LAT];
  logic [OP_W-1:0] opr [LAT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) begin
        vld[i] <= 1'b0;
        opr[i] <= '0;
      end
    end else begin
      vld[0] <= in_v;
      opr[0] <= in_op;
      for (int i = 1; i < LAT; i++) begin
        vld[i] <= vld[i-1];
        opr[i] <= opr[i-1];
      end
    end
  end

  assign out_v  = vld[LAT-1];
  assign out_op = opr[LAT-1];
endmodule

// File: rtl/grp_lane_seq.sv
module grp_lane_seq #(
  parameter int GROUP_W  = 64,
  parameter int UNIT_W   = 16,
  parameter int OP_W     = 6,
  parameter int PIPE_LAT = 3,
  localparam int NSLICE  = GROUP_W / UNIT_W,
  localparam int SIDX_W  = (NSLICE > 1) ? $clog2(NSLICE) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                iss_valid,
  input  logic [OP_W-1:0]     iss_op,
  input  logic [GROUP_W-1:0]  iss_mask,
  output logic                iss_ready,
  output logic                iss_unit,
  output logic [1:0]          sl_valid,
  output logic [2*SIDX_W-1:0] sl_idx,
  output logic [2*UNIT_W-1:0] sl_mask,
  output logic [2*OP_W-1:0]   sl_op,
  output logic [1:0]          cmp_valid,
  output logic [2*OP_W-1:0]   cmp_op
);
  import lseq_pkg::*;

  logic [1:0] busy;
  logic [1:0] fin;
  logic [1:0] load;
  logic       accept;
  unit_id_t   prev_unit;
  unit_id_t   pick;

  assign pick      = pick_unit(~busy, prev_unit);
  assign iss_ready = !(busy[0] && busy[1]);
  assign iss_unit  = pick;
  assign accept    = iss_valid && iss_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_unit <= 1'b1;
    else if (accept) prev_unit <= pick;
  end

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic [OP_W-1:0] op_u;
    assign load[u] = accept && (pick == unit_id_t'(u));

    lseq_slicer #(.GROUP_W(GROUP_W), .UNIT_W(UNIT_W), .OP_W(OP_W)) u_slc (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load[u]),
      .ld_op    (iss_op),
      .ld_mask  (iss_mask),
      .busy     (busy[u]),
      .fin      (fin[u]),
      .sl_valid (sl_valid[u]),
      .sl_idx   (sl_idx[u*SIDX_W +: SIDX_W]),
      .sl_mask  (sl_mask[u*UNIT_W +: UNIT_W]),
      .sl_op    (op_u)
    );
    assign sl_op[u*OP_W +: OP_W] = op_u;

    lseq_delay #(.LAT(PIPE_LAT), .OP_W(OP_W)) u_dly (
      .clk    (clk),
      .rst_n  (rst_n),
      .in_v   (fin[u]),
      .in_op  (op_u),
      .out_v  (cmp_valid[u]),
      .out_op (cmp_op[u*OP_W +: OP_W])
    );
  end
endmodule

// File: rtl/lseq_chk.sv
module lseq_chk #(
  parameter int UNIT_W = 16,
  parameter int SIDX_W = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          load,
  input logic [1:0]          busy,
  input logic [1:0]          sl_valid,
  input logic [2*SIDX_W-1:0] sl_idx,
  input logic [2*UNIT_W-1:0] sl_mask
);
  // R2
  first_slice_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load[0] |=> (sl_idx[SIDX_W-1:0] == '0));

  // R2
  slice_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy[0] |=> (sl_idx[SIDX_W-1:0] == $past(sl_idx[SIDX_W-1:0]) + 1'b1));

  // R3
  no_load_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy == 2'b11) |-> (load == 2'b00));

  // R6
  zero_slice0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sl_valid[0] |-> (|sl_mask[UNIT_W-1:0]));

  // R6
  zero_slice1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sl_valid[1] |-> (|sl_mask[2*UNIT_W-1:UNIT_W]));
endmodule

bind grp_lane_seq lseq_chk #(.UNIT_W(UNIT_W), .SIDX_W(SIDX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .load     (load),
  .busy     (busy),
  .sl_valid (sl_valid),
  .sl_idx   (sl_idx),
  .sl_mask  (sl_mask)
);

// File: tb/sim_grp_lane_seq.sv
module sim_grp_lane_seq;
  localparam int GROUP_W = 64;
  localparam int UNIT_W  = 16;
  localparam int OP_W    = 6;
  localparam int LAT     = 3;
  localparam int NS      = GROUP_W / UNIT_W;
  localparam int SIDX_W  = 2;

  logic clk = 0;
  logic rst_n = 0;
  logic iss_valid = 0;
  logic [OP_W-1:0] iss_op = '0;
  logic [GROUP_W-1:0] iss_mask = '0;
  logic iss_ready, iss_unit;
  logic [1:0] sl_valid, cmp_valid;
  logic [2*SIDX_W-1:0] sl_idx;
  logic [2*UNIT_W-1:0] sl_mask;
  logic [2*OP_W-1:0] sl_op, cmp_op;

  always #5 clk = ~clk;

  grp_lane_seq #(.GROUP_W(GROUP_W), .UNIT_W(UNIT_W), .OP_W(OP_W), .PIPE_LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op), .iss_mask(iss_mask),
    .iss_ready(iss_ready), .iss_unit(iss_unit), .sl_valid(sl_valid), .sl_idx(sl_idx),
    .sl_mask(sl_mask), .sl_op(sl_op), .cmp_valid(cmp_valid), .cmp_op(cmp_op));

  typedef struct packed { int cyc; int idx; logic [UNIT_W-1:0] m; logic v; logic [OP_W-1:0] op; } slice_t;
  typedef struct packed { int cyc; logic [OP_W-1:0] op; } done_t;
  slice_t sq0[$], sq1[$];
  done_t  dq0[$], dq1[$];

  int cyc = 0;
  int nchk = 0, nerr = 0;
  int acc_at[2] = '{-100, -100};
  bit last_u = 1;
  bit mon_on = 0;
  bit ended = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, expv, cyc);
    end
  endtask

  task automatic push_expect(input int u, input int c, input logic [OP_W-1:0] op,
                             input logic [GROUP_W-1:0] m);
    for (int k = 0; k < NS; k++) begin
      slice_t e;
      logic [GROUP_W-1:0] sh;
      sh = m >> (k * UNIT_W);
      e.cyc = c + 1 + k; e.idx = k; e.m = sh[UNIT_W-1:0]; e.v = (e.m != 0); e.op = op;
      if (u == 0) sq0.push_back(e); else sq1.push_back(e);
    end
    begin
      done_t d;
      d.cyc = c + NS + LAT; d.op = op;
      if (u == 0) dq0.push_back(d); else dq1.push_back(d);
    end
  endtask

  // driver: offer one instruction for one cycle, predicting acceptance and steering
  task automatic offer(input logic [OP_W-1:0] op, input logic [GROUP_W-1:0] m, output bit took);
    bit f0, f1, er;
    int eu;
    @(negedge clk);
    iss_valid = 1; iss_op = op; iss_mask = m;
    f0 = (cyc >= acc_at[0] + NS);
    f1 = (cyc >= acc_at[1] + NS);
    er = f0 || f1;
    chk(iss_ready == er, "R3", "iss_ready", iss_ready, er);
    took = er;
    if (er) begin
      if (f0 && f1) eu = last_u ? 0 : 1;
      else eu = f0 ? 0 : 1;
      chk(iss_unit == eu[0], "R5", "iss_unit", iss_unit, eu);
      push_expect(eu, cyc, op, m);
      acc_at[eu] = cyc;
      last_u = eu[0];
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      iss_valid = 0; iss_mask = '0; iss_op = '0;
    end
  endtask

  task automatic mon_unit(input int u);
    logic v, dv;
    logic [SIDX_W-1:0] ix;
    logic [UNIT_W-1:0] mm;
    logic [OP_W-1:0] op, dop;
    v = sl_valid[u]; ix = sl_idx[u*SIDX_W +: SIDX_W]; mm = sl_mask[u*UNIT_W +: UNIT_W];
    op = sl_op[u*OP_W +: OP_W]; dv = cmp_valid[u]; dop = cmp_op[u*OP_W +: OP_W];
    if (u == 0 ? (sq0.size() > 0 && sq0[0].cyc == cyc) : (sq1.size() > 0 && sq1[0].cyc == cyc)) begin
      slice_t e;
      e = (u == 0) ? sq0.pop_front() : sq1.pop_front();
      chk(v == e.v, e.v ? "R2" : "R6", "sl_valid", v, e.v);
      chk(ix == e.idx[SIDX_W-1:0], "R6", "sl_idx", ix, e.idx);
      if (e.v) begin
        chk(mm == e.m, "R2", "sl_mask", mm, e.m);
        chk(op == e.op, "R2", "sl_op", op, e.op);
      end
    end else begin
      chk(v == 0, "R3", "unexpected sl_valid", v, 0);
    end
    if (u == 0 ? (dq0.size() > 0 && dq0[0].cyc == cyc) : (dq1.size() > 0 && dq1[0].cyc == cyc)) begin
      done_t d;
      d = (u == 0) ? dq0.pop_front() : dq1.pop_front();
      chk(dv == 1'b1, "R7", "cmp_valid", dv, 1);
      chk(dop == d.op, "R7", "cmp_op", dop, d.op);
    end else begin
      chk(dv == 0, "R7", "unexpected cmp_valid", dv, 0);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      mon_unit(0);
      mon_unit(1);
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 20000 && !ended) begin
      ended = 1;
      nchk++; nerr++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    bit took;
    int tries;
    logic [GROUP_W-1:0] r;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(iss_ready == 1, "R1", "iss_ready", iss_ready, 1);
    chk(iss_unit == 0, "R1", "iss_unit", iss_unit, 0);
    chk(sl_valid == 0, "R1", "sl_valid", sl_valid, 0);
    chk(cmp_valid == 0, "R1", "cmp_valid", cmp_valid, 0);
    mon_on = 1;

    // R2 R8: two back-to-back, overlapping on both units
    offer(6'h01, {GROUP_W{1'b1}}, took);
    offer(6'h02, 64'h8000_0001_0F0F_1234, took);
    // R3: both busy, offers refused until a unit frees (R4)
    tries = 0;
    do begin
      offer(6'h03, 64'hFFFF_0000_FFFF_0001, took);
      tries++;
    end while (!took && tries < 10);
    chk(tries > 1, "R3", "refusal observed", tries, 2);
    // R6: zero slices inside a mask, and an all-zero mask (R7 still completes)
    offer(6'h04, 64'h0000_ABCD_0000_0001, took);
    idle(12);
    offer(6'h05, 64'h0, took);
    idle(12);
    // R5 alternation when both free
    offer(6'h06, 64'h0001_0002_0004_0008, took);
    idle(12);
    offer(6'h07, 64'hF000_0F00_00F0_000F, took);
    idle(12);
    // R8 sustained stream
    r = 64'h1357_9BDF_2468_ACE0;
    for (int i = 0; i < 40; i++) begin
      r = {r[62:0], r[63] ^ r[62] ^ r[60] ^ r[59]};
      if (i % 5 == 0) r[31:16] = '0;
      offer(6'(8 + i), r, took);
    end
    idle(NS + LAT + 6);
    chk(sq0.size() + sq1.size() == 0, "R2", "slices outstanding", sq0.size() + sq1.size(), 0);
    chk(dq0.size() + dq1.size() == 0, "R7", "completions outstanding", dq0.size() + dq1.size(), 0);
    ended = 1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule